// File: doc/BRIEF.md
# Battery Status Supervisor

This controller watches two battery-level flags and a charger-present flag on a handheld payment terminal. It drives a green "battery fine" indicator and a request for the display to show a low-battery advisory. That advisory tells the user to finish and pay, or to move to another unit. When the level becomes critical, the controller runs a fixed shutdown sequence. The sequence posts a last warning, then orders a wipe of stored data, then drops the secure link, and finally powers the unit down.

With the charger present, the controller sits in a charging state with every output quiet. When the charger is removed, it returns to whichever level state the flags currently describe. Before the shutdown sequence starts, the controller re-evaluates the level flags on every clock. Once the sequence has started, it runs to completion no matter what the flags or the charger do. After that it stays powered off until reset. Each shutdown step lasts a parameterised number of clock cycles.

Top module: `batt_guard`

## Requirements
- R1: After reset, only `led_ok` is high (the good state), regardless of the flag inputs during reset.
- R2: Outside the shutdown sequence, with `chg_in` low, the flags are decoded by priority: `bat_crit` wins over `bat_low`, and `bat_low` wins over neither. The result is shown one clock after the inputs are sampled. Good gives `led_ok`, low gives `msg_low`, and critical starts the sequence with `warn_final`.
- R3: The good and low states follow the flags on every clock, so clearing `bat_low` while in the low state returns the block to good one clock later.
- R4: Outside the shutdown sequence, `chg_in` high moves the block to charging one clock later, even when `bat_crit` is high. In the charging state all six outputs are low.
- R5: When `chg_in` falls in the charging state, the block enters the state matching the flags one clock later: good, low, or the start of the shutdown sequence.
- R6: The shutdown sequence asserts `warn_final`, then `cmd_clear`, then `cmd_disc`, then `cmd_off`, in that order and with no other state in between.
- R7: `warn_final` is held for WARN_CYC cycles, `cmd_clear` for CLEAR_CYC cycles and `cmd_disc` for DISC_CYC cycles (defaults 4, 3, 2).
- R8: Once the sequence has started, `chg_in`, `bat_low` and `bat_crit` have no effect. `cmd_off` stays high until reset.
- R9: At most one of the six outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bat_low | input | 1 | Battery level is low |
| bat_crit | input | 1 | Battery level is critical |
| chg_in | input | 1 | Charger is plugged in |
| led_ok | output | 1 | Green indicator, battery good |
| msg_low | output | 1 | Request for the low-battery advisory |
| warn_final | output | 1 | Final warning before shutdown |
| cmd_clear | output | 1 | Command to wipe stored data |
| cmd_disc | output | 1 | Command to drop the secure connection |
| cmd_off | output | 1 | Power-off command |

## Verification
The assertions check on every cycle that at most one output is high. They also check that each shutdown step can only stay put or advance to the next step, that power-off is sticky, and that charger entry and critical entry happen one clock after the inputs ask for them. Only the bench scenarios can show the following: the exact length of each step; the full priority table across every flag combination from each start state; the return to the matching state on unplug; and the recovery from low to good.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

  typedef enum logic [2:0] {
    ST_GOOD, ST_LOW, ST_CHG, ST_WARN, ST_CLEAR, ST_DISC, ST_OFF
  } bg_state_e;

  // Priority decode of the level flags: critical over low over good (R2)
  function automatic bg_state_e level_target(input logic crit, input logic low);
    if (crit)      return ST_WARN;
    else if (low)  return ST_LOW;
    else           return ST_GOOD;
  endfunction

  function automatic logic in_shutdown(input bg_state_e s);
    return (s == ST_WARN) || (s == ST_CLEAR) || (s == ST_DISC) || (s == ST_OFF);
  endfunction

endpackage

// File: rtl/bg_level_prio.sv
module bg_level_prio
  import batt_guard_pkg::*;
(
  input  logic      crit,
  input  logic      low,
  input  logic      chg,
  output bg_state_e target
);
  // Charger presence outranks every level flag before the sequence (R4)
  always_comb begin
    if (chg) target = ST_CHG;
    else     target = level_target(crit, low);
  end
endmodule

// File: rtl/bg_hold_timer.sv
module bg_hold_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] last_idx,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == last_idx);
endmodule

// File: rtl/bg_seq_fsm.sv
module bg_seq_fsm
  import batt_guard_pkg::*;
#(
  parameter int WARN_CYC  = 4,
  parameter int CLEAR_CYC = 3,
  parameter int DISC_CYC  = 2,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bg_state_e        target,
  input  logic             expired,
  output bg_state_e        cur,
  output logic             restart,
  output logic [CNT_W-1:0] last_idx
);
  localparam logic [CNT_W-1:0] WARN_LAST  = CNT_W'(WARN_CYC - 1);
  localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(CLEAR_CYC - 1);
  localparam logic [CNT_W-1:0] DISC_LAST  = CNT_W'(DISC_CYC - 1);

  bg_state_e nxt;

  always_comb begin
    nxt = cur;
    case (cur)
      ST_GOOD, ST_LOW, ST_CHG: nxt = target;
      ST_WARN:  if (expired) nxt = ST_CLEAR;
      ST_CLEAR: if (expired) nxt = ST_DISC;
      ST_DISC:  if (expired) nxt = ST_OFF;
      ST_OFF:   nxt = ST_OFF;
      default:  nxt = ST_GOOD;
    endcase
  end

  always_comb begin
    case (cur)
      ST_WARN:  last_idx = WARN_LAST;
      ST_CLEAR: last_idx = CLEAR_LAST;
      ST_DISC:  last_idx = DISC_LAST;
      default:  last_idx = '0;
    endcase
  end

  assign restart = (nxt != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_GOOD;
    else        cur <= nxt;
  end

  assert_seq_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_shutdown(cur) |=> in_shutdown(cur));
  assert_warn_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_WARN) |=> (cur == ST_WARN || cur == ST_CLEAR));
  assert_clear_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_CLEAR) |=> (cur == ST_CLEAR || cur == ST_DISC));
  assert_disc_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_DISC) |=> (cur == ST_DISC || cur == ST_OFF));
  assert_off_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_OFF) |=> (cur == ST_OFF));
endmodule

// File: rtl/batt_guard.sv
module batt_guard
  import batt_guard_pkg::*;
#(
  parameter int WARN_CYC  = 4,
  parameter int CLEAR_CYC = 3,
  parameter int DISC_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bat_low,
  input  logic bat_crit,
  input  logic chg_in,
  output logic led_ok,
  output logic msg_low,
  output logic warn_final,
  output logic cmd_clear,
  output logic cmd_disc,
  output logic cmd_off
);
  localparam int MAX_A   = (WARN_CYC > CLEAR_CYC) ? WARN_CYC : CLEAR_CYC;
  localparam int MAX_CYC = (MAX_A > DISC_CYC) ? MAX_A : DISC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  bg_state_e        target;
  bg_state_e        state;
  logic             restart;
  logic             expired;
  logic [CNT_W-1:0] last_idx;
  logic             seq_active;

  bg_level_prio u_prio (
    .crit   (bat_crit),
    .low    (bat_low),
    .chg    (chg_in),
    .target (target)
  );

  bg_seq_fsm #(
    .WARN_CYC (WARN_CYC), .CLEAR_CYC (CLEAR_CYC),
    .DISC_CYC (DISC_CYC), .CNT_W (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .target   (target),
    .expired  (expired),
    .cur      (state),
    .restart  (restart),
    .last_idx (last_idx)
  );

  bg_hold_timer #(.CNT_W (CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .last_idx (last_idx),
    .expired  (expired)
  );

  assign seq_active = in_shutdown(state);
  assign led_ok     = (state == ST_GOOD);
  assign msg_low    = (state == ST_LOW);
  assign warn_final = (state == ST_WARN);
  assign cmd_clear  = (state == ST_CLEAR);
  assign cmd_disc   = (state == ST_DISC);
  assign cmd_off    = (state == ST_OFF);

  assert_onehot_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({led_ok, msg_low, warn_final, cmd_clear, cmd_disc, cmd_off}));
  assert_charge_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_active && chg_in) |=> !(led_ok || msg_low || warn_final || cmd_clear || cmd_disc || cmd_off));
  assert_crit_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_active && !chg_in && bat_crit) |=> warn_final);
endmodule

// File: tb/test_batt_guard.sv
module test_batt_guard;
  localparam int W = 4, C = 3, D = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bat_low = 1'b0, bat_crit = 1'b0, chg_in = 1'b0;
  logic led_ok, msg_low, warn_final, cmd_clear, cmd_disc, cmd_off;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  batt_guard #(.WARN_CYC(W), .CLEAR_CYC(C), .DISC_CYC(D)) i_batt_guard (
    .clk, .rst_n, .bat_low, .bat_crit, .chg_in,
    .led_ok, .msg_low, .warn_final, .cmd_clear, .cmd_disc, .cmd_off
  );

  // model codes: 0 good, 1 low, 2 charging, 3 warn, 4 clear, 5 disc, 6 off
  function automatic logic [5:0] vec_of(input int s);
    case (s)
      0: return 6'b100000;
      1: return 6'b010000;
      3: return 6'b001000;
      4: return 6'b000100;
      5: return 6'b000010;
      6: return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic int next_of(input bit crit, input bit low, input bit chg);
    if (chg) return 2;
    if (crit) return 3;
    if (low) return 1;
    return 0;
  endfunction

  task automatic check(input logic [5:0] exp, input string tag);
    logic [5:0] got;
    got = {led_ok, msg_low, warn_final, cmd_clear, cmd_disc, cmd_off};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state with flags held high during reset
    bat_crit = 1'b1; bat_low = 1'b1; chg_in = 1'b1;
    @(negedge clk);
    do_reset();
    check(vec_of(0), "R1 reset");

    // Sweep: every flag combination from each non-shutdown start state
    for (int st = 0; st < 3; st++) begin
      for (int combo = 0; combo < 8; combo++) begin
        bit cr, lo, ch;
        string tag;
        cr = combo[2]; lo = combo[1]; ch = combo[0];
        bat_crit = 1'b0; bat_low = (st == 1); chg_in = (st == 2);
        do_reset();
        step();
        check(vec_of(st), st == 2 ? "R4 enter charging" : "R2 level start");
        bat_crit = cr; bat_low = lo; chg_in = ch;
        step();
        if (ch)                 tag = "R4 charger priority";
        else if (st == 2)       tag = "R5 unplug return";
        else if (st == 1 && !cr && !lo) tag = "R3 low recovers";
        else                    tag = "R2 priority decode";
        check(vec_of(next_of(cr, lo, ch)), tag);
      end
    end

    // Shutdown sequence: order, durations, inputs ignored, sticky off
    bat_crit = 1'b0; bat_low = 1'b0; chg_in = 1'b0;
    do_reset();
    bat_crit = 1'b1;
    step();
    for (int k = 0; k < W + C + D + 5; k++) begin
      int s;
      if (k < W)              s = 3;
      else if (k < W + C)     s = 4;
      else if (k < W + C + D) s = 5;
      else                    s = 6;
      check(vec_of(s), s == 6 ? "R8 off sticky" : "R7 step length R6 order");
      chg_in = k[0]; bat_low = k[1]; bat_crit = (k % 3 == 0);
      step();
    end

    // Reset out of power-off
    bat_crit = 1'b0; bat_low = 1'b0; chg_in = 1'b0;
    do_reset();
    check(vec_of(0), "R1 reset after off");

    finish_run();
  end
endmodule